// File: doc/BRIEF.md
# Four-Phase Tagged Sample Formatter

This block is the digital back end of a dead-timeless integrating digitizer. Integration is spread over four rotating slots. A free-running 2-bit slot counter advances once per system clock and labels every slot. During each slot the block takes one converted sample: a 6-bit mantissa, a 2-bit range exponent and a 6-bit arrival-time code. It subtracts the pedestal programmed for that slot's phase from the mantissa. It then packs the result and the phase tag into a 16-bit word. That word comes out exactly four slots later, in the slot that carries the same phase again, so a phase's previous result leaves while its next integration is under way.

The word is available in parallel. It is also serialised as two 8-bit halves on a double-rate clock: the upper half in the first double-rate period of the slot and the lower half in the second. This doubles the rate of a narrow parallel link. The four 6-bit pedestals live in a 24-bit serial configuration register. The register is shifted in bit by bit and only becomes active when its load strobe drops. A reset returns the pedestals to their parameter defaults, so programming is optional.

The double-rate clock must be phase aligned with the system clock (rising edges coincide). Reset is synchronous to the system clock and must be released after a system-clock rising edge, before the next double-rate edge.

Top module: `tagged_sample_fmt`

## Requirements
- R1: While reset is high, and in the first slot after its release, the slot phase is 0, both valid outputs are 0 and all pedestals equal the default parameter (zero by default).
- R2: `slot_phase` advances by one, modulo 4, at every system clock rising edge outside reset.
- R3: A sample presented during slot k appears on `word_out` during slot k+4, tagged with the phase of slot k, which is also the phase shown in slot k+4.
- R4: Word layout: bits [15:14] phase tag, [13:12] exponent, [11:6] adjusted mantissa, [5:0] time code.
- R5: `word_valid` is 0 for the first four slots after reset and 1 from slot 4 onward until the next reset.
- R6: The adjusted mantissa is mantissa minus the pedestal of the sample's phase, floored at 0. The pedestal for phase p sits in configuration bits [6p+5:6p].
- R7: While `cfg_load` is 1, each slot in which `cfg_sclk` is 1 after being 0 in the previous slot shifts `cfg_sdi` into bit 0, moving the other bits up; the first bit shifted ends at bit 23 after 24 shifts. The active pedestals keep their old values until the slot in which `cfg_load` falls. Samples from the next slot onward use the copied contents.
- R8: `cfg_sclk` edges while `cfg_load` is 0 leave the shift register unchanged, so a later load strobe without shifts reapplies the same pedestals.
- R9: In slot k+4, `ddr_half` carries word bits [15:8] with `ddr_first`=1 during the first double-rate period, then bits [7:0] with `ddr_first`=0 during the second. `ddr_valid` follows `word_valid` for the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (slot) clock |
| clk2x | input | 1 | Double-rate clock, rising edges aligned to clk |
| rst | input | 1 | Synchronous reset, active high |
| smp_mant | input | 6 | Sample mantissa for the current slot |
| smp_exp | input | 2 | Sample range exponent |
| smp_time | input | 6 | Sample arrival-time code |
| cfg_sclk | input | 1 | Serial configuration clock, sampled by clk |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Shift enable; falling edge applies contents |
| slot_phase | output | 2 | Phase of the current slot |
| word_out | output | 16 | Packed result released this slot |
| word_valid | output | 1 | word_out holds a real result |
| ddr_half | output | 8 | Half of the current word on the double-rate clock |
| ddr_first | output | 1 | ddr_half carries the upper half |
| ddr_valid | output | 1 | ddr_half belongs to a valid word |

## Verification
A sample driven in slot k is due on `word_out` one nanosecond after the rising edge that opens slot k+4. Its upper half is due on `ddr_half` at the same instant, and its lower half one nanosecond after the mid-slot double-rate edge of that slot. The bench keeps a table of expected words indexed by slot count and compares each output at exactly those instants, never at an edge. A configuration change is modelled as taking effect on the sample of the slot after the one in which the load strobe falls. The expected pedestal switches at that point and not earlier.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int MANT_W = 6;
    localparam int EXP_W  = 2;
    localparam int TIME_W = 6;
    localparam int TAG_W  = 2;
    localparam int NPHASE = 1 << TAG_W;
    localparam int LAT    = NPHASE;
    localparam int WORD_W = TAG_W + EXP_W + MANT_W + TIME_W;
    localparam int HALF_W = WORD_W / 2;
    localparam int PED_W  = MANT_W;
    localparam int CFG_W  = NPHASE * PED_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
        logic [TIME_W-1:0] tcode;
    } word_t;
endpackage

// File: rtl/tsf_cfg.sv
module tsf_cfg
    import tsf_pkg::*;
#(
    parameter logic [CFG_W-1:0] PED_DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             sdi,
    input  logic             load,
    output logic [CFG_W-1:0] ped_o
);
    typedef struct packed {
        logic [CFG_W-1:0] shreg;
        logic [CFG_W-1:0] active;
        logic             sclk_q;
        logic             load_q;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d        = cfg_q;
        cfg_d.sclk_q = sclk;
        cfg_d.load_q = load;
        // shift on a serial clock rising edge while enabled
        if (load && sclk && !cfg_q.sclk_q) begin
            cfg_d.shreg = {cfg_q.shreg[CFG_W-2:0], sdi};
        end
        // apply on the falling edge of the enable
        if (cfg_q.load_q && !load) begin
            cfg_d.active = cfg_q.shreg;
        end
        if (rst) begin
            cfg_d.shreg  = '0;
            cfg_d.active = PED_DEFAULT;
            cfg_d.load_q = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign ped_o = cfg_q.active;

    // R7: active pedestals only move on an enable fall
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(cfg_q.load_q && !load) |=> $stable(ped_o));

    // R8: no shifting while the enable is low
    p_cfg_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q.shreg));
endmodule

// File: rtl/tsf_pipe.sv
module tsf_pipe
    import tsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  expo_i,
    input  logic [TIME_W-1:0] tcode_i,
    input  logic [CFG_W-1:0]  ped_i,
    output logic [TAG_W-1:0]  phase_o,
    output word_t             word_o,
    output logic              valid_o,
    output word_t             tap_o,
    output logic              tap_valid_o
);
    typedef struct packed {
        logic [TAG_W-1:0]      phase;
        word_t [LAT-1:0]       data;
        logic [LAT-1:0]        vld;
    } pipe_st_t;

    pipe_st_t pipe_d, pipe_q;
    logic [PED_W-1:0]  ped_sel;
    logic [MANT_W-1:0] mant_adj;
    word_t             capture;

    always_comb begin
        ped_sel  = ped_i[PED_W*int'(pipe_q.phase) +: PED_W];
        mant_adj = (mant_i > ped_sel) ? (mant_i - ped_sel) : '0;
        capture  = '{tag: pipe_q.phase, expo: expo_i, mant: mant_adj, tcode: tcode_i};

        pipe_d         = pipe_q;
        pipe_d.phase   = pipe_q.phase + 1'b1;
        pipe_d.data[0] = capture;
        pipe_d.vld[0]  = 1'b1;
        for (int i = 1; i < LAT; i++) begin
            pipe_d.data[i] = pipe_q.data[i-1];
            pipe_d.vld[i]  = pipe_q.vld[i-1];
        end
        if (rst) begin
            pipe_d.phase = '0;
            pipe_d.data  = '0;
            pipe_d.vld   = '0;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign phase_o     = pipe_q.phase;
    assign word_o      = pipe_q.data[LAT-1];
    assign valid_o     = pipe_q.vld[LAT-1];
    assign tap_o       = pipe_q.data[LAT-2];
    assign tap_valid_o = pipe_q.vld[LAT-2];

    // R2: phase steps by one each clock
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_o == TAG_W'($past(phase_o) + 1'b1));

    // R3: a released word carries the phase of the current slot
    p_tag_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> word_o.tag == phase_o);

    // R5: once valid, stays valid until reset
    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);
endmodule

// File: rtl/tsf_ddr.sv
module tsf_ddr
    import tsf_pkg::*;
(
    input  logic              clk2x,
    input  logic              rst,
    input  word_t             tap_i,
    input  logic              tap_valid_i,
    output logic [HALF_W-1:0] half_o,
    output logic              first_o,
    output logic              dvalid_o
);
    typedef struct packed {
        logic              mid;
        word_t             hold;
        logic              hold_v;
        logic [HALF_W-1:0] half;
        logic              first;
        logic              dv;
    } ddr_st_t;

    ddr_st_t ddr_d, ddr_q;

    always_comb begin
        ddr_d = ddr_q;
        if (ddr_q.mid) begin
            // mid-slot edge: send lower half, take next word while stable
            ddr_d.half   = ddr_q.hold[HALF_W-1:0];
            ddr_d.first  = 1'b0;
            ddr_d.dv     = ddr_q.hold_v;
            ddr_d.hold   = tap_i;
            ddr_d.hold_v = tap_valid_i;
            ddr_d.mid    = 1'b0;
        end else begin
            // slot-start edge: send upper half
            ddr_d.half  = ddr_q.hold[WORD_W-1 -: HALF_W];
            ddr_d.first = 1'b1;
            ddr_d.dv    = ddr_q.hold_v;
            ddr_d.mid   = 1'b1;
        end
        if (rst) begin
            ddr_d.mid    = 1'b1;
            ddr_d.hold   = '0;
            ddr_d.hold_v = 1'b0;
            ddr_d.half   = '0;
            ddr_d.first  = 1'b0;
            ddr_d.dv     = 1'b0;
        end
    end

    always_ff @(posedge clk2x) begin
        ddr_q <= ddr_d;
    end

    assign half_o   = ddr_q.half;
    assign first_o  = ddr_q.first;
    assign dvalid_o = ddr_q.dv;

    // R9: an upper half is always followed by a lower half
    p_half_order_r9: assert property (@(posedge clk2x) disable iff (rst)
        first_o |=> !first_o);

    // R9: a valid lower half belongs to a valid upper half
    p_half_pair_r9: assert property (@(posedge clk2x) disable iff (rst)
        (dvalid_o && !first_o) |-> $past(dvalid_o));
endmodule

// File: rtl/tagged_sample_fmt.sv
module tagged_sample_fmt
    import tsf_pkg::*;
#(
    parameter logic [CFG_W-1:0] PED_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              clk2x,
    input  logic              rst,
    input  logic [MANT_W-1:0] smp_mant,
    input  logic [EXP_W-1:0]  smp_exp,
    input  logic [TIME_W-1:0] smp_time,
    input  logic              cfg_sclk,
    input  logic              cfg_sdi,
    input  logic              cfg_load,
    output logic [TAG_W-1:0]  slot_phase,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic [HALF_W-1:0] ddr_half,
    output logic              ddr_first,
    output logic              ddr_valid
);
    logic [CFG_W-1:0] ped;
    word_t            word_w;
    word_t            tap_w;
    logic             tap_v;

    tsf_cfg #(.PED_DEFAULT(PED_DEFAULT)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .sclk  (cfg_sclk),
        .sdi   (cfg_sdi),
        .load  (cfg_load),
        .ped_o (ped)
    );

    tsf_pipe u_pipe (
        .clk         (clk),
        .rst         (rst),
        .mant_i      (smp_mant),
        .expo_i      (smp_exp),
        .tcode_i     (smp_time),
        .ped_i       (ped),
        .phase_o     (slot_phase),
        .word_o      (word_w),
        .valid_o     (word_valid),
        .tap_o       (tap_w),
        .tap_valid_o (tap_v)
    );

    tsf_ddr u_ddr (
        .clk2x       (clk2x),
        .rst         (rst),
        .tap_i       (tap_w),
        .tap_valid_i (tap_v),
        .half_o      (ddr_half),
        .first_o     (ddr_first),
        .dvalid_o    (ddr_valid)
    );

    assign word_out = word_w;

    // R1: nothing valid while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !word_valid);
endmodule

// File: tb/tb_tagged_sample_fmt.sv
`timescale 1ns/1ps
module tb_tagged_sample_fmt;
    logic        clk = 1'b0, clk2x = 1'b0, rst = 1'b1;
    logic [5:0]  smp_mant = '0, smp_time = '0;
    logic [1:0]  smp_exp = '0;
    logic        cfg_sclk = 1'b0, cfg_sdi = 1'b0, cfg_load = 1'b0;
    logic [1:0]  slot_phase;
    logic [15:0] word_out;
    logic        word_valid;
    logic [7:0]  ddr_half;
    logic        ddr_first, ddr_valid;

    tagged_sample_fmt dut (.*);

    initial forever #2.5 clk2x = ~clk2x;
    initial begin #2.5; clk = 1'b1; forever #5 clk = ~clk; end

    int tests = 0, fails = 0, k = 0;
    bit done = 0;
    logic [15:0] expw [0:1023];
    logic [23:0] ped_m = '0, shd_m = '0;
    logic        sclk_prev = 0, load_prev = 0;

    task automatic chk(input string rq, input string what, input logic [15:0] got, input logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s slot %0d: got %h exp %h", rq, what, k, got, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [5:0] m, input logic [1:0] e,
                                          input logic [5:0] t, input logic [1:0] ph,
                                          input logic [23:0] pd);
        logic [5:0] pm, ma;
        pm = pd[6*int'(ph) +: 6];
        ma = (m > pm) ? m - pm : 6'd0;
        return {ph, e, ma, t};
    endfunction

    task automatic do_reset();
        rst = 1'b1; cfg_sclk = 0; cfg_load = 0; cfg_sdi = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "valid in reset", {15'b0, word_valid}, 16'd0);
        rst = 1'b0;
        k = 0; ped_m = '0; shd_m = '0; sclk_prev = 0; load_prev = 0;
        chk("R1", "phase after reset", {14'b0, slot_phase}, 16'd0);
    endtask

    task automatic slot(input string rq, input logic [5:0] m, input logic [1:0] e,
                        input logic [5:0] t, input logic sc, input logic sd, input logic ld);
        logic [15:0] w;
        chk("R2", "phase", {14'b0, slot_phase}, 16'(k % 4));
        if (k >= 4) begin
            w = expw[(k-4) % 1024];
            chk(rq, "word", word_out, w);
            chk("R4", "tag field", {14'b0, word_out[15:14]}, 16'((k-4) % 4));
            chk("R6", "mantissa field", {10'b0, word_out[11:6]}, {10'b0, w[11:6]});
            chk("R5", "valid", {15'b0, word_valid}, 16'd1);
            chk("R9", "upper half", {ddr_valid, ddr_first, 6'b0, ddr_half}, {2'b11, 6'b0, w[15:8]});
        end else begin
            chk("R5", "valid low", {15'b0, word_valid}, 16'd0);
            chk("R1", "ddr valid low", {15'b0, ddr_valid}, 16'd0);
        end
        smp_mant = m; smp_exp = e; smp_time = t;
        cfg_sclk = sc; cfg_sdi = sd; cfg_load = ld;
        expw[k % 1024] = model(m, e, t, 2'(k % 4), ped_m);
        if (ld && sc && !sclk_prev) shd_m = {shd_m[22:0], sd};
        if (load_prev && !ld) ped_m = shd_m;
        sclk_prev = sc; load_prev = ld;
        #5;
        if (k >= 4) begin
            w = expw[(k-4) % 1024];
            chk("R9", "lower half", {ddr_valid, ddr_first, 6'b0, ddr_half}, {2'b10, 6'b0, w[7:0]});
        end
        @(posedge clk); #1;
        k++;
    endtask

    localparam logic [23:0] PROG = {6'd63, 6'd0, 6'd17, 6'd5};

    initial begin
        do_reset();
        // R3: sweep every mantissa/exponent pair with zero pedestals
        for (int i = 0; i < 256; i++)
            slot("R3", 6'(i % 64), 2'(i / 64), 6'((i * 5 + 3) % 64), 0, 0, 0);
        // R7: shift in new pedestals; old ones must stay active meanwhile
        for (int b = 23; b >= 0; b--) begin
            slot("R7", 6'(b + 20), 2'(b % 4), 6'(b), 0, PROG[b], 1);
            slot("R7", 6'(b + 40), 2'(b % 4), 6'(b * 2), 1, PROG[b], 1);
        end
        slot("R7", 6'd33, 2'd1, 6'd9, 0, 0, 0);
        // R6: pedestal subtraction with floor per phase
        for (int i = 0; i < 128; i++)
            slot("R6", 6'((i * 3) % 64), 2'(i % 4), 6'(63 - (i % 64)), 0, 0, 0);
        // R8: serial clock edges with enable low, then an empty strobe
        for (int i = 0; i < 8; i++)
            slot("R8", 6'(i * 7), 2'd2, 6'd1, 1'(i % 2), 1, 0);
        slot("R8", 6'd50, 2'd3, 6'd2, 0, 1, 1);
        slot("R8", 6'd51, 2'd3, 6'd3, 0, 1, 0);
        for (int i = 0; i < 16; i++)
            slot("R8", 6'(i * 4 + 2), 2'(i % 4), 6'(i), 0, 0, 0);
        // R1: reset mid-run flushes and restores default pedestals
        do_reset();
        for (int i = 0; i < 64; i++)
            slot("R1", 6'(63 - i), 2'(i % 4), 6'(i), 0, 0, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL R3 watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule